// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two IEEE-754 floating-point operands, either single or double precision, and produces the two-bit condition code that later conditional branches read. A caller places both operand words on the inputs. It chooses the precision and picks either a quiet compare or a signaling compare, then pulses the valid strobe for one cycle. One clock later the block returns three results: the status word with the condition-code field updated, an invalid-operation flag for the exception recorder, and a result strobe.

The compare handles signed zeros, infinities, subnormals, quiet NaNs and signaling NaNs. Some compares raise invalid while the invalid trap is enabled. For those, the results are inhibited: the status word goes back unchanged and only the invalid flag reports the event.

Top module: `fpcc_top`

## Requirements
- R1: The condition code in status bits 11:10 is 0 when operand A equals operand B, 1 when A is less than B, and 2 when A is greater than B, following numeric order from negative infinity through the subnormals to positive infinity.
- R2: Positive zero and negative zero compare as equal, giving code 0.
- R3: If either operand is a NaN, the code is 3 (unordered). A NaN has an all-ones exponent and a nonzero fraction.
- R4: A signaling compare (`signaling` = 1) that gives the unordered result raises `invalid_exc`. An ordered result never raises it.
- R5: If an operand is a signaling NaN (fraction MSB = 0), `invalid_exc` is raised even for a quiet compare. A quiet compare whose NaN operands are all quiet (fraction MSB = 1) gives code 3 and leaves `invalid_exc` low.
- R6: Every status bit other than 11:10 is passed from `stat_in` to `stat_out` unchanged.
- R7: If `invalid_exc` is raised while `inv_trap_en` is 1, the result is inhibited and bits 11:10 of `stat_out` keep the value of `stat_in`.
- R8: In single precision (`is_double` = 0), only bits 31:0 of each operand are used: sign in bit 31, exponent in bits 30:23, fraction in bits 22:0. Bits 63:32 have no effect. In double precision the sign is bit 63, the exponent bits 62:52 and the fraction bits 51:0.
- R9: The results appear one clock after the cycle in which `cmp_valid` is high, with `res_valid` high for exactly that cycle. In a cycle after one with no request, `res_valid` and `invalid_exc` are low and `stat_out` holds its value.
- R10: After reset, `res_valid`, `invalid_exc` and `stat_out` are all zero.
- R11: When both operands are negative, the order is the reverse of the order of their magnitudes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare request strobe |
| is_double | input | 1 | 1 selects double precision, 0 selects single |
| signaling | input | 1 | 1 selects the signaling compare variant |
| inv_trap_en | input | 1 | Invalid-operation trap enable; inhibits the write |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Operand B |
| stat_in | input | 32 | Current status word |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| stat_out | output | 32 | Status word with the condition code merged in |
| invalid_exc | output | 1 | Invalid-operation exception flag |

## Verification
The assertions assume that `stat_in`, `inv_trap_en` and `signaling` are stable in the cycle in which `cmp_valid` is high. The R6 and R7 checks use `$past` of those inputs at that edge. They also assume that a request lasts exactly one cycle for each compare. Back-to-back requests are allowed. The stimulus drives all inputs on the falling edge and raises the strobe for one cycle per transaction, with the status word and trap enable already in place. It sweeps every pair of a ranked value set in both precisions, both compare variants and both trap settings. In single-precision runs it puts varying patterns in the unused upper halves.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int WORD_W    = 64;
  localparam int MAG_W     = WORD_W - 1;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } cc_e;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             snan;
    logic             zero;
  } opnd_t;

  // Same-sign ordering of two magnitudes; neg reverses the sense.
  function automatic cc_e mag_order(input logic [MAG_W-1:0] ma,
                                    input logic [MAG_W-1:0] mb,
                                    input logic             neg);
    cc_e r;
    if (ma == mb)            r = CC_EQ;
    else if ((ma < mb) ^ neg) r = CC_LT;
    else                     r = CC_GT;
    return r;
  endfunction

  // Order of two non-NaN operands of differing sign.
  function automatic cc_e sign_order(input logic sa);
    return sa ? CC_LT : CC_GT;
  endfunction

endpackage

// File: rtl/fpcc_unpack.sv
module fpcc_unpack
  import fpcc_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int EXP_S  = SP_EXP_W,
  parameter int FRAC_S = SP_FRAC_W,
  parameter int EXP_D  = DP_EXP_W,
  parameter int FRAC_D = DP_FRAC_W
) (
  input  logic [W-1:0] word,
  input  logic         is_double,
  output opnd_t        op
);
  localparam int SIGN_S = EXP_S + FRAC_S;
  localparam int SIGN_D = EXP_D + FRAC_D;

  logic exp_ones, frac_nz, frac_msb;

  always_comb begin
    if (is_double) begin
      op.sign  = word[SIGN_D];
      op.mag   = MAG_W'(word[SIGN_D-1:0]);
      exp_ones = &word[SIGN_D-1:FRAC_D];
      frac_nz  = |word[FRAC_D-1:0];
      frac_msb = word[FRAC_D-1];
    end else begin
      op.sign  = word[SIGN_S];
      op.mag   = MAG_W'(word[SIGN_S-1:0]);
      exp_ones = &word[SIGN_S-1:FRAC_S];
      frac_nz  = |word[FRAC_S-1:0];
      frac_msb = word[FRAC_S-1];
    end
    op.nan  = exp_ones & frac_nz;
    op.snan = exp_ones & frac_nz & ~frac_msb;
    op.zero = (op.mag == '0);
  end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
(
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             nan_a,
  input  logic             zero_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_b,
  input  logic             zero_b,
  output cc_e              cc
);
  always_comb begin
    if (nan_a || nan_b)        cc = CC_UN;
    else if (zero_a && zero_b) cc = CC_EQ;
    else if (sign_a != sign_b) cc = sign_order(sign_a);
    else                       cc = mag_order(mag_a, mag_b, sign_a);
  end
endmodule

// File: rtl/fpcc_top.sv
module fpcc_top
  import fpcc_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              is_double,
  input  logic              signaling,
  input  logic              inv_trap_en,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [STAT_W-1:0] stat_in,
  output logic              res_valid,
  output logic [STAT_W-1:0] stat_out,
  output logic              invalid_exc
);
  localparam int N_OPND = 2;
  localparam int CC_MSB = CC_LSB + 1;

  opnd_t             ops [N_OPND];
  logic [DATA_W-1:0] words [N_OPND];
  cc_e               cc_w;
  logic              nan_any_w, snan_any_w, invalid_w, inhibit_w;
  logic [STAT_W-1:0] stat_next;

  assign words[0] = src_a;
  assign words[1] = src_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_unpack
    fpcc_unpack #(.W(DATA_W)) u_unpack (
      .word      (words[g]),
      .is_double (is_double),
      .op        (ops[g])
    );
  end

  fpcc_order u_order (
    .sign_a (ops[0].sign), .mag_a (ops[0].mag),
    .nan_a  (ops[0].nan),  .zero_a (ops[0].zero),
    .sign_b (ops[1].sign), .mag_b (ops[1].mag),
    .nan_b  (ops[1].nan),  .zero_b (ops[1].zero),
    .cc     (cc_w)
  );

  assign nan_any_w  = ops[0].nan  | ops[1].nan;
  assign snan_any_w = ops[0].snan | ops[1].snan;
  assign invalid_w  = (cc_w == CC_UN) & (signaling | snan_any_w);
  assign inhibit_w  = invalid_w & inv_trap_en;

  always_comb begin
    stat_next = stat_in;
    if (!inhibit_w) stat_next[CC_MSB:CC_LSB] = cc_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      invalid_exc <= 1'b0;
      stat_out    <= '0;
    end else begin
      res_valid   <= cmp_valid;
      invalid_exc <= cmp_valid & invalid_w;
      if (cmp_valid) stat_out <= stat_next;
    end
  end
endmodule

// File: rtl/fpcc_chk.sv
module fpcc_chk #(
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic              signaling,
  input logic              inv_trap_en,
  input logic [STAT_W-1:0] stat_in,
  input logic              res_valid,
  input logic [STAT_W-1:0] stat_out,
  input logic              invalid_exc,
  input logic              nan_any_w,
  input logic              snan_any_w,
  input logic              invalid_w
);
  localparam int CC_MSB = CC_LSB + 1;

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> (!res_valid && !invalid_exc && $stable(stat_out)));

  assert_keep_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (stat_out[STAT_W-1:CC_MSB+1] == $past(stat_in[STAT_W-1:CC_MSB+1]) &&
                   stat_out[CC_LSB-1:0] == $past(stat_in[CC_LSB-1:0])));

  assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && invalid_w && inv_trap_en) |=>
      (invalid_exc && stat_out[CC_MSB:CC_LSB] == $past(stat_in[CC_MSB:CC_LSB])));

  assert_quiet_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && nan_any_w && !signaling && !snan_any_w) |=> !invalid_exc);

  assert_snan_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && snan_any_w) |=> invalid_exc);

  assert_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && nan_any_w && !inv_trap_en) |=> (stat_out[CC_MSB:CC_LSB] == 2'b11));

  assert_sig_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && nan_any_w && signaling) |=> invalid_exc);
endmodule

bind fpcc_top fpcc_chk #(.STAT_W(STAT_W), .CC_LSB(CC_LSB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_valid   (cmp_valid),
  .signaling   (signaling),
  .inv_trap_en (inv_trap_en),
  .stat_in     (stat_in),
  .res_valid   (res_valid),
  .stat_out    (stat_out),
  .invalid_exc (invalid_exc),
  .nan_any_w   (nan_any_w),
  .snan_any_w  (snan_any_w),
  .invalid_w   (invalid_w)
);

// File: tb/tb_fpcc_top.sv
module tb_fpcc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0, is_double = 1'b0, signaling = 1'b0, inv_trap_en = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [31:0] stat_in = '0;
  logic        res_valid, invalid_exc;
  logic [31:0] stat_out;

  int n_chk = 0, n_bad = 0, cyc = 0;

  fpcc_top dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .is_double(is_double),
    .signaling(signaling), .inv_trap_en(inv_trap_en), .src_a(src_a), .src_b(src_b),
    .stat_in(stat_in), .res_valid(res_valid), .stat_out(stat_out), .invalid_exc(invalid_exc)
  );

  always #5 clk = ~clk;

  // Value set: bit patterns, numeric rank, NaN and signaling-NaN flags.
  localparam int NV = 13;
  logic [31:0] sv [NV];
  logic [63:0] dv [NV];
  int          rk [NV];
  bit          nn [NV];
  bit          sn [NV];

  task automatic put(input int i, input logic [31:0] s, input logic [63:0] d,
                     input int r, input bit isn, input bit iss);
    sv[i] = s; dv[i] = d; rk[i] = r; nn[i] = isn; sn[i] = iss;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  // One request, sampled on the falling edge after the capturing rising edge.
  task automatic run_one(input int ia, input int ib, input bit dbl, input bit sg,
                         input bit te, input logic [31:0] hi, input logic [31:0] st);
    logic [1:0]  exp_cc;
    bit          exp_inv;
    logic [31:0] exp_st;
    string       tag;
    is_double = dbl; signaling = sg; inv_trap_en = te; stat_in = st;
    src_a = dbl ? dv[ia] : {hi, sv[ia]};
    src_b = dbl ? dv[ib] : {~hi, sv[ib]};
    cmp_valid = 1'b1;
    if (nn[ia] || nn[ib])       begin exp_cc = 2'd3; tag = "R3"; end
    else if (rk[ia] == rk[ib])  begin exp_cc = 2'd0; tag = (rk[ia] == 0) ? "R2" : "R1"; end
    else if (rk[ia] < rk[ib])   begin exp_cc = 2'd1; tag = (rk[ia] < 0 && rk[ib] < 0) ? "R11" : "R1"; end
    else                        begin exp_cc = 2'd2; tag = (rk[ia] < 0 && rk[ib] < 0) ? "R11" : "R1"; end
    if (!dbl) tag = {tag, "/R8"};
    exp_inv = (exp_cc == 2'd3) && (sg || sn[ia] || sn[ib]);
    exp_st  = st;
    if (!(exp_inv && te)) exp_st[11:10] = exp_cc;
    @(negedge clk);
    cmp_valid = 1'b0;
    check("R9 res_valid", 32'(res_valid), 32'd1);
    check((sn[ia] || sn[ib]) ? "R5 invalid" : "R4 invalid", 32'(invalid_exc), 32'(exp_inv));
    check("R6 other bits", stat_out & ~32'hC00, st & ~32'hC00);
    if (exp_inv && te) check("R7 inhibited cc", 32'(stat_out[11:10]), 32'(st[11:10]));
    else               check(tag, 32'(stat_out[11:10]), 32'(exp_cc));
  endtask

  initial begin
    put(0,  32'hFF800000, 64'hFFF0000000000000, -4, 0, 0); // -inf
    put(1,  32'hC0000000, 64'hC000000000000000, -3, 0, 0); // -2
    put(2,  32'hBF800000, 64'hBFF0000000000000, -2, 0, 0); // -1
    put(3,  32'h80000001, 64'h8000000000000001, -1, 0, 0); // -subnormal
    put(4,  32'h00000000, 64'h0000000000000000,  0, 0, 0); // +0
    put(5,  32'h80000000, 64'h8000000000000000,  0, 0, 0); // -0
    put(6,  32'h00000001, 64'h0000000000000001,  1, 0, 0); // +subnormal
    put(7,  32'h3F800000, 64'h3FF0000000000000,  2, 0, 0); // +1
    put(8,  32'h3FC00000, 64'h3FF8000000000000,  3, 0, 0); // +1.5
    put(9,  32'h7F800000, 64'h7FF0000000000000,  4, 0, 0); // +inf
    put(10, 32'h7FC00000, 64'h7FF8000000000000,  0, 1, 0); // quiet NaN
    put(11, 32'h7F800001, 64'h7FF0000000000001,  0, 1, 1); // signaling NaN
    put(12, 32'hFFC00000, 64'hFFF8000000000000,  0, 1, 0); // negative quiet NaN

    repeat (3) @(negedge clk);
    check("R10 res_valid", 32'(res_valid), 32'd0);
    check("R10 invalid_exc", 32'(invalid_exc), 32'd0);
    check("R10 stat_out", stat_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < NV; a++) begin
        for (int b = 0; b < NV; b++) begin
          run_one(a, b, m[0], m[1], m[2], 32'h7FF80000 ^ 32'(a * 977 + b * 131 + m),
                  32'hA5A5_5A5A ^ 32'(a * 4099 + b * 61 + m * 7));
        end
      end
    end

    // R8: upper halves form a double NaN but single operands are +1 and +1.
    run_one(7, 7, 1'b0, 1'b1, 1'b0, 32'h7FF80000, 32'h0000_0C00);

    // R9: idle cycles hold the status and keep the strobes low.
    begin
      logic [31:0] held;
      held = stat_out;
      stat_in = ~held;
      src_a = 64'h7FF0000000000001;
      signaling = 1'b1;
      repeat (2) begin
        @(negedge clk);
        check("R9 idle res_valid", 32'(res_valid), 32'd0);
        check("R9 idle invalid_exc", 32'(invalid_exc), 32'd0);
        check("R9 idle stat_out", stat_out, held);
      end
    end
    finish_run();
  end
endmodule